// File: doc/BRIEF.md
# Master Clock Source and Output Routing Controller

This block picks the master-clock source for an audio receiver. It chooses between the clock recovered by a PLL and a crystal oscillator clock, using a 2-bit operating mode and the PLL unlock flag. The same choice steers the serial data output, which carries either the received data or an auxiliary input. It also steers the sample-rate indicator, which comes either from the recovered-rate flag or from the crystal-rate flag. The block drives the power enables of the PLL and of the oscillator. The analog PLL and the oscillator themselves are outside this block.

In the fallback mode, losing lock moves everything over to the crystal path on its own. When lock returns, the block moves back. Each clock source has its own enable leg. A leg synchronises the request into its own clock domain and waits until the other leg has released before it turns on. Because of this, a change of source never produces a shortened pulse.

Two master-clock outputs are produced. The second output either equals the first or is the first divided by two, as set by a 2-bit ratio code. The fourth ratio code is a test setting that holds both outputs low. The 512fs setting is not meant for 96 kHz sampling. The block does not enforce this.

Top module: `mclk_route_ctrl`

## Requirements
- R1: The power enables follow the mode. Mode 0 gives pll_en=1, osc_en=0. Mode 1 gives pll_en=0, osc_en=1. Modes 2 and 3 give pll_en=1, osc_en=1. The unlock flag has no effect on either enable.
- R2: The crystal path is active in mode 1, in mode 3, and in mode 2 while unlock=1. While it is active, sdata_out equals aux_data and rate_out equals rate_xtal. Otherwise sdata_out equals rx_data and rate_out equals rate_rec, including in mode 0 with unlock=1.
- R3: A few source-clock cycles after a mode or unlock change, mclk_a runs from xtal_clk whenever the crystal path is active and from rec_clk otherwise.
- R4: At no time are both source enables on. No high or low phase of mclk_a is shorter than the shorter half-period of the two source clocks.
- R5: With ratio code 0, mclk_b equals mclk_a.
- R6: With ratio codes 1 and 2, mclk_b toggles on each rising edge of mclk_a, so it runs at half the frequency of mclk_a.
- R7: With ratio code 3, mclk_a and mclk_b are both held low.
- R8: While rst_n is low, the recovered-clock leg is selected and the divider output is held low. As a result, mclk_b shows no edges under ratio codes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rec_clk | input | 1 | Clock recovered by the PLL |
| xtal_clk | input | 1 | Crystal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode 0..3 |
| ratio | input | 2 | Output clock ratio code 0..3 |
| unlock | input | 1 | PLL unlock flag, 1 = not locked |
| rx_data | input | 1 | Received serial data |
| aux_data | input | 1 | Auxiliary serial data input |
| rate_rec | input | 1 | Rate indicator derived from the recovered clock |
| rate_xtal | input | 1 | Rate indicator set for crystal operation |
| mclk_a | output | 1 | First master-clock output |
| mclk_b | output | 1 | Second master-clock output |
| sdata_out | output | 1 | Routed serial data output |
| rate_out | output | 1 | Routed rate indicator |
| pll_en | output | 1 | PLL power enable |
| osc_en | output | 1 | Oscillator power enable |

## Verification
The assertions assume that both source clocks keep toggling whenever a switch is pending. A leg can only release its enable on an edge of its own clock. The assertions also assume that the ratio code is steady around the output edges they sample. The stimulus keeps both clocks free-running for the whole run and changes mode, unlock and ratio only on a falling edge of the crystal clock. Pulse-width measurement is paused while the ratio code moves into or out of the test setting, because that gating is combinational and is not meant to be glitch-free.

// File: rtl/mclk_pkg.sv
`timescale 1ns/1ps
package mclk_pkg;
   typedef enum logic [1:0] {
      OPM_RECOVERED = 2'd0,
      OPM_CRYSTAL   = 2'd1,
      OPM_FALLBACK  = 2'd2,
      OPM_MONITOR   = 2'd3
   } op_mode_e;

   typedef enum logic [1:0] {
      RAT_EQUAL  = 2'd0,
      RAT_HALF   = 2'd1,
      RAT_DOUBLE = 2'd2,
      RAT_TEST   = 2'd3
   } ratio_e;
endpackage

// File: rtl/mclk_mode_decode.sv
`timescale 1ns/1ps
module mclk_mode_decode
   import mclk_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       unlock,
   output logic       pll_en,
   output logic       osc_en,
   output logic       use_xtal
);
   op_mode_e m;
   assign m = op_mode_e'(mode);

   always_comb begin
      pll_en   = 1'b1;
      osc_en   = 1'b1;
      use_xtal = 1'b1;
      unique case (m)
         OPM_RECOVERED: begin osc_en = 1'b0; use_xtal = 1'b0;   end
         OPM_CRYSTAL:   begin pll_en = 1'b0;                    end
         OPM_FALLBACK:  begin use_xtal = unlock;                end
         OPM_MONITOR:   begin                                   end
         default:       begin                                   end
      endcase
   end
endmodule

// File: rtl/mclk_clk_leg.sv
`timescale 1ns/1ps
module mclk_clk_leg #(
   parameter int unsigned NUM_SYNC = 2,
   parameter bit          RST_ON   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic other_en,
   output logic en
);
   if (NUM_SYNC < 2) begin : g_bad_sync
      $error("mclk_clk_leg: NUM_SYNC must be at least 2");
   end

   logic [NUM_SYNC-1:0] sync_q;

   if (NUM_SYNC == 2) begin : g_sync2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= {NUM_SYNC{RST_ON}};
         else        sync_q <= {sync_q[0], want & ~other_en};
      end
   end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= {NUM_SYNC{RST_ON}};
         else        sync_q <= {sync_q[NUM_SYNC-2:0], want & ~other_en};
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en <= RST_ON;
      else        en <= sync_q[NUM_SYNC-1];
   end
endmodule

// File: rtl/mclk_ratio_div.sv
`timescale 1ns/1ps
module mclk_ratio_div
   import mclk_pkg::*;
(
   input  logic       clk_in,
   input  logic       rst_n,
   input  logic [1:0] ratio,
   output logic       clk_a,
   output logic       clk_b
);
   ratio_e r;
   logic   half_q;
   logic   test_sel;

   assign r        = ratio_e'(ratio);
   assign test_sel = (r == RAT_TEST);

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) half_q <= 1'b0;
      else        half_q <= ~half_q;
   end

   always_comb begin
      clk_a = clk_in & ~test_sel;
      unique case (r)
         RAT_EQUAL:  clk_b = clk_in;
         RAT_HALF,
         RAT_DOUBLE: clk_b = half_q;
         default:    clk_b = 1'b0;
      endcase
   end
endmodule

// File: rtl/mclk_route_ctrl.sv
`timescale 1ns/1ps
module mclk_route_ctrl #(
   parameter int unsigned NUM_SYNC = 2
) (
   input  logic       rec_clk,
   input  logic       xtal_clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic [1:0] ratio,
   input  logic       unlock,
   input  logic       rx_data,
   input  logic       aux_data,
   input  logic       rate_rec,
   input  logic       rate_xtal,
   output logic       mclk_a,
   output logic       mclk_b,
   output logic       sdata_out,
   output logic       rate_out,
   output logic       pll_en,
   output logic       osc_en
);
   logic use_xtal;
   logic en_rec;
   logic en_xtal;
   logic clk_sel;

   mclk_mode_decode u_dec (
      .mode     (mode),
      .unlock   (unlock),
      .pll_en   (pll_en),
      .osc_en   (osc_en),
      .use_xtal (use_xtal)
   );

   mclk_clk_leg #(.NUM_SYNC(NUM_SYNC), .RST_ON(1'b1)) u_leg_rec (
      .clk      (rec_clk),
      .rst_n    (rst_n),
      .want     (~use_xtal),
      .other_en (en_xtal),
      .en       (en_rec)
   );

   mclk_clk_leg #(.NUM_SYNC(NUM_SYNC), .RST_ON(1'b0)) u_leg_xtal (
      .clk      (xtal_clk),
      .rst_n    (rst_n),
      .want     (use_xtal),
      .other_en (en_rec),
      .en       (en_xtal)
   );

   assign clk_sel = (rec_clk & en_rec) | (xtal_clk & en_xtal);

   mclk_ratio_div u_div (
      .clk_in (clk_sel),
      .rst_n  (rst_n),
      .ratio  (ratio),
      .clk_a  (mclk_a),
      .clk_b  (mclk_b)
   );

   assign sdata_out = use_xtal ? aux_data  : rx_data;
   assign rate_out  = use_xtal ? rate_xtal : rate_rec;
endmodule

// File: rtl/mclk_route_ctrl_chk.sv
`timescale 1ns/1ps
module mclk_route_ctrl_chk (
   input logic       xtal_clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic [1:0] ratio,
   input logic       unlock,
   input logic       aux_data,
   input logic       rx_data,
   input logic       sdata_out,
   input logic       mclk_a,
   input logic       mclk_b,
   input logic       pll_en,
   input logic       osc_en,
   input logic       en_rec,
   input logic       en_xtal
);
   // R4: the two source legs never drive the output together
   a_r4_one_leg: assert property (@(negedge xtal_clk) disable iff (!rst_n)
      $onehot0({en_rec, en_xtal}));

   // R1: crystal-only mode keeps the PLL powered down
   a_r1_crystal_power: assert property (@(negedge xtal_clk) disable iff (!rst_n)
      (mode == 2'd1) |-> (!pll_en && osc_en));

   // R2: locked fallback mode passes received data through
   a_r2_locked_rx: assert property (@(negedge xtal_clk) disable iff (!rst_n)
      (mode == 2'd2 && !unlock) |-> (sdata_out == rx_data));

   // R2: monitor mode routes the auxiliary input
   a_r2_monitor_aux: assert property (@(negedge xtal_clk) disable iff (!rst_n)
      (mode == 2'd3) |-> (sdata_out == aux_data));

   // R7: test ratio silences both outputs
   a_r7_test_low: assert property (@(negedge xtal_clk) disable iff (!rst_n)
      (ratio == 2'd3) |-> (!mclk_a && !mclk_b));
endmodule

bind mclk_route_ctrl mclk_route_ctrl_chk u_chk (
   .xtal_clk  (xtal_clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .ratio     (ratio),
   .unlock    (unlock),
   .aux_data  (aux_data),
   .rx_data   (rx_data),
   .sdata_out (sdata_out),
   .mclk_a    (mclk_a),
   .mclk_b    (mclk_b),
   .pll_en    (pll_en),
   .osc_en    (osc_en),
   .en_rec    (en_rec),
   .en_xtal   (en_xtal)
);

// File: tb/test_mclk_route_ctrl.sv
`timescale 1ns/1ps
module test_mclk_route_ctrl;
   logic       xtal_clk = 1'b0;
   logic       rec_clk  = 1'b0;
   logic       rst_n    = 1'b0;
   logic [1:0] mode     = 2'd0;
   logic [1:0] ratio    = 2'd0;
   logic       unlock   = 1'b0;
   logic       rx_data  = 1'b1;
   logic       aux_data = 1'b0;
   logic       rate_rec = 1'b0;
   logic       rate_xtal = 1'b1;
   logic       mclk_a, mclk_b, sdata_out, rate_out, pll_en, osc_en;

   int checks = 0;
   int fails  = 0;
   int na = 0;
   int nb = 0;
   bit cnt_on = 1'b0;
   bit pw_on  = 1'b0;
   int runts  = 0;
   bit done   = 1'b0;
   realtime t_edge = 0.0;

   always #2 xtal_clk = ~xtal_clk;   // 250 MHz
   always #3 rec_clk  = ~rec_clk;    // ~167 MHz

   mclk_route_ctrl i_mclk_route_ctrl (
      .rec_clk(rec_clk), .xtal_clk(xtal_clk), .rst_n(rst_n),
      .mode(mode), .ratio(ratio), .unlock(unlock),
      .rx_data(rx_data), .aux_data(aux_data),
      .rate_rec(rate_rec), .rate_xtal(rate_xtal),
      .mclk_a(mclk_a), .mclk_b(mclk_b), .sdata_out(sdata_out),
      .rate_out(rate_out), .pll_en(pll_en), .osc_en(osc_en)
   );

   always @(posedge mclk_a) if (cnt_on) na++;
   always @(posedge mclk_b) if (cnt_on) nb++;

   // phase width monitor for R4
   always @(mclk_a) begin
      if (pw_on && ($realtime - t_edge) < 1.9) runts++;
      t_edge = $realtime;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_window();
      na = 0; nb = 0;
      cnt_on = 1'b1;
      #120;
      cnt_on = 1'b0;
   endtask

   function automatic bit near(input int a, input int e);
      return (a >= e - 1) && (a <= e + 1);
   endfunction

   // {mode, unlock, exp_pll, exp_osc, exp_xtal_path}
   localparam logic [5:0] VEC [6] = '{
      {2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
      {2'd1, 1'b0, 1'b0, 1'b1, 1'b1},
      {2'd2, 1'b0, 1'b1, 1'b1, 1'b0},
      {2'd2, 1'b1, 1'b1, 1'b1, 1'b1},
      {2'd3, 1'b0, 1'b1, 1'b1, 1'b1},
      {2'd0, 1'b1, 1'b1, 1'b0, 1'b0}
   };

   initial begin
      #200000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R8: reset holds the divider low under ratio 1
      ratio = 2'd1;
      #10;
      count_window();
      chk(nb == 0, "R8 mclk_b edges in reset", nb, 0);
      chk(near(na, 20), "R8 mclk_a from rec_clk in reset", na, 20);
      chk(pll_en == 1'b1 && osc_en == 1'b0, "R1 reset enables", {pll_en, osc_en}, 2);
      @(negedge xtal_clk);
      rst_n = 1'b1;
      ratio = 2'd0;
      #60;
      pw_on = 1'b1;

      for (int i = 0; i < 6; i++) begin
         @(negedge xtal_clk);
         mode   = VEC[i][5:4];
         unlock = VEC[i][3];
         rx_data = 1'b1; aux_data = 1'b0; rate_rec = 1'b0; rate_xtal = 1'b1;
         #1;
         chk(pll_en == VEC[i][2], "R1 pll_en", pll_en, VEC[i][2]);
         chk(osc_en == VEC[i][1], "R1 osc_en", osc_en, VEC[i][1]);
         chk(sdata_out == ~VEC[i][0], "R2 sdata_out", sdata_out, ~VEC[i][0]);
         chk(rate_out == VEC[i][0], "R2 rate_out", rate_out, VEC[i][0]);
         rx_data = 1'b0; aux_data = 1'b1; rate_rec = 1'b1; rate_xtal = 1'b0;
         #1;
         chk(sdata_out == VEC[i][0], "R2 sdata_out flipped", sdata_out, VEC[i][0]);
         chk(rate_out == ~VEC[i][0], "R2 rate_out flipped", rate_out, ~VEC[i][0]);
         #100;
         count_window();
         chk(near(na, VEC[i][0] ? 30 : 20), "R3 mclk_a source", na, VEC[i][0] ? 30 : 20);
         chk(na == nb, "R5 mclk_b equals mclk_a", nb, na);
      end

      // R6: divide-by-two under codes 1 and 2 (crystal source, mode 1)
      @(negedge xtal_clk); mode = 2'd1; unlock = 1'b0;
      #100;
      for (int r = 1; r <= 2; r++) begin
         @(negedge xtal_clk); ratio = 2'(r);
         #20;
         count_window();
         chk(near(na, 30), "R6 mclk_a unchanged", na, 30);
         chk(near(nb, 15), "R6 mclk_b halved", nb, 15);
      end

      // R7: test ratio holds both low
      pw_on = 1'b0;
      @(negedge xtal_clk); ratio = 2'd3;
      #20;
      count_window();
      chk(na == 0, "R7 mclk_a silent", na, 0);
      chk(nb == 0, "R7 mclk_b silent", nb, 0);
      chk(mclk_a == 1'b0 && mclk_b == 1'b0, "R7 outputs low", {mclk_a, mclk_b}, 0);
      @(negedge xtal_clk); ratio = 2'd0;
      #20;
      pw_on = 1'b1;

      // R4: repeated fallback switching under unlock toggles
      @(negedge xtal_clk); mode = 2'd2;
      for (int k = 0; k < 8; k++) begin
         @(negedge xtal_clk); unlock = ~unlock;
         #37;
      end
      #100;
      pw_on = 1'b0;
      chk(runts == 0, "R4 runt phases on mclk_a", runts, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule